// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit multiplies two signed operands and adds the product into a 64-bit signed accumulator. The accumulator is held as an upper and a lower 32-bit register. Two operation widths exist. The long form multiplies full 32-bit operands. The word form multiplies only the low 16 bits of each operand. A per-operation saturation bit picks between wrap-around accumulation and clamped accumulation, and each width clamps in its own way. The host can read both halves at any time. It can write either half while the unit is idle, and it can clear both halves at once.

Operations arrive on a valid/ready handshake. An operation is taken on any cycle where `in_valid` and `in_ready` are both high. `in_ready` drops for the one cycle in which an operation is in flight, and also in any cycle where `clr` is high. While `in_ready` is low the source must hold its request. The result side has no back-pressure: the accumulator registers are updated in place and a one-cycle `done` pulse marks the update. The fastest issue rate is one operation every two cycles.

Top module: `sat_mac_unit`

## Requirements
- R1: After reset both accumulator halves read zero, `done` is low and `in_ready` is high.
- R2: In the long form with saturation off, the product of the two sign-extended 32-bit operands is added to the 64-bit value {hi, lo}. The upper 32 bits of the sum go to hi and the lower 32 bits go to lo.
- R3: In the word form, bits 15:0 of each operand are sign-extended and multiplied, and bits 31:16 have no effect. With saturation off, the full 64-bit sum is written back.
- R4: In the long form with saturation on, lo takes the lower half of the sum. If the sum is negative, hi takes the upper half with bits 31:16 forced to ones. Otherwise hi takes the upper half with everything above bit 14 cleared.
- R5: In the word form with saturation on, a sum below -2^31 sets hi to 1 and lo to 0x80000000.
- R6: In the word form with saturation on, a sum above 2^31-1 sets hi to 1 and lo to 0x7FFFFFFF. A sum inside that range is written back as the full 64-bit sum.
- R7: An accepted operation updates the accumulator on the second rising edge after acceptance, counting the accepting edge as the first. `done` is high for exactly the one cycle after that update. `in_ready` is low in the cycle between the two edges, and a request held during that cycle is not taken.
- R8: `clr` zeroes both halves on the next edge. It also holds `in_ready` low, so a request offered in the same cycle is not taken and produces no `done`.
- R9: `clr` raised while an operation is in flight cancels that operation: the accumulator reads zero and no `done` follows.
- R10: When idle, `hi_wr` or `lo_wr` loads its data into that half on the next edge. During the in-flight cycle the writes are ignored, and the accumulator holds the operation's result.
- R11: A write in the same cycle as an accepted request loads first, and the operation then accumulates onto the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_word | input | 1 | 1 = word form (16-bit operands), 0 = long form |
| in_sat | input | 1 | 1 = clamped accumulation |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| clr | input | 1 | Zero both accumulator halves |
| hi_wr | input | 1 | Load the upper half |
| hi_wdata | input | 32 | Data for the upper half |
| lo_wr | input | 1 | Load the lower half |
| lo_wdata | input | 32 | Data for the lower half |
| hi_q | output | 32 | Upper accumulator half |
| lo_q | output | 32 | Lower accumulator half |
| done | output | 1 | One-cycle pulse after an accumulator update |

## Verification
Clear and a new request can land in the same cycle, and so can a host write and either the accepting cycle or the in-flight cycle of an operation. Directed steps drive `clr` together with `in_valid` and together with an operation in flight. They also drive `hi_wr` and `lo_wr` alongside acceptance and during the busy cycle. A behavioural model in the bench applies the stated priority: clear first, then the in-flight result, then host writes. It judges `in_ready`, both halves and `done` on every cycle, with random traffic mixing all of these.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  typedef enum logic {
    MAC_LONG = 1'b0,
    MAC_WORD = 1'b1
  } mac_width_e;

  typedef struct packed {
    mac_width_e width;
    logic       sat;
  } mac_ctl_t;
endpackage

// File: rtl/sat_mac_mult.sv
module sat_mac_mult
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  mac_ctl_t                 ctl_in,
  input  logic [DATA_W-1:0]        op_a,
  input  logic [DATA_W-1:0]        op_b,
  output logic                     prod_vld,
  output mac_ctl_t                 ctl_q,
  output logic signed [2*DATA_W-1:0] prod_q
);
  localparam int ACC_W = 2 * DATA_W;
  localparam int EXT_W = DATA_W - HALF_W;

  logic [DATA_W-1:0] sel_a, sel_b;
  logic signed [ACC_W-1:0] wide_a, wide_b, prod_d;

  // choose full operand or sign-extended low half
  always_comb begin
    if (ctl_in.width == MAC_WORD) begin
      sel_a = {{EXT_W{op_a[HALF_W-1]}}, op_a[HALF_W-1:0]};
      sel_b = {{EXT_W{op_b[HALF_W-1]}}, op_b[HALF_W-1:0]};
    end else begin
      sel_a = op_a;
      sel_b = op_b;
    end
    wide_a = {{DATA_W{sel_a[DATA_W-1]}}, sel_a};
    wide_b = {{DATA_W{sel_b[DATA_W-1]}}, sel_b};
    prod_d = wide_a * wide_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_vld <= 1'b0;
      prod_q   <= '0;
      ctl_q    <= '{width: MAC_LONG, sat: 1'b0};
    end else begin
      prod_vld <= load;
      if (load) begin
        prod_q <= prod_d;
        ctl_q  <= ctl_in;
      end
    end
  end
endmodule

// File: rtl/sat_mac_accum.sv
module sat_mac_accum
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       prod_vld,
  input  mac_ctl_t                   ctl,
  input  logic signed [2*DATA_W-1:0] prod,
  input  logic                       hi_wr,
  input  logic [DATA_W-1:0]          hi_wdata,
  input  logic                       lo_wr,
  input  logic [DATA_W-1:0]          lo_wdata,
  output logic [DATA_W-1:0]          hi_q,
  output logic [DATA_W-1:0]          lo_q,
  output logic                       done
);
  localparam int ACC_W = 2 * DATA_W;
  localparam logic signed [ACC_W-1:0] WORD_MAX =
    {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] WORD_MIN =
    {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] NEG_FILL  = {{HALF_W{1'b1}}, {(DATA_W-HALF_W){1'b0}}};
  localparam logic [DATA_W-1:0] POS_KEEP  = {{(DATA_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] OVF_MARK  = DATA_W'(1);
  localparam logic [DATA_W-1:0] LO_MAXPOS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] LO_MAXNEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_now, sum;
  logic [DATA_W-1:0] hi_nxt, lo_nxt;

  always_comb begin
    acc_now = {hi_q, lo_q};
    sum     = acc_now + prod;
    hi_nxt  = sum[ACC_W-1:DATA_W];
    lo_nxt  = sum[DATA_W-1:0];
    if (ctl.sat) begin
      if (ctl.width == MAC_LONG) begin
        if (sum[ACC_W-1]) hi_nxt = sum[ACC_W-1:DATA_W] | NEG_FILL;
        else              hi_nxt = sum[ACC_W-1:DATA_W] & POS_KEEP;
      end else if (sum < WORD_MIN) begin
        hi_nxt = OVF_MARK;
        lo_nxt = LO_MAXNEG;
      end else if (sum > WORD_MAX) begin
        hi_nxt = OVF_MARK;
        lo_nxt = LO_MAXPOS;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      done <= 1'b0;
    end else if (clr) begin
      hi_q <= '0;
      lo_q <= '0;
      done <= 1'b0;
    end else if (prod_vld) begin
      hi_q <= hi_nxt;
      lo_q <= lo_nxt;
      done <= 1'b1;
    end else begin
      done <= 1'b0;
      if (hi_wr) hi_q <= hi_wdata;
      if (lo_wr) lo_q <= lo_wdata;
    end
  end

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hi_q == '0 && lo_q == '0));

  p_idle_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !prod_vld && !clr) |=> hi_q == $past(hi_wdata));

  p_word_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_vld && !clr && ctl.sat && ctl.width == MAC_WORD) |=>
      (hi_q == OVF_MARK || hi_q == {DATA_W{lo_q[DATA_W-1]}}));

  p_long_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_vld && !clr && ctl.sat && ctl.width == MAC_LONG) |=>
      (hi_q[DATA_W-1:DATA_W-HALF_W] == '1 || hi_q[DATA_W-1:HALF_W-1] == '0));
endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_word,
  input  logic              in_sat,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              clr,
  input  logic              hi_wr,
  input  logic [DATA_W-1:0] hi_wdata,
  input  logic              lo_wr,
  input  logic [DATA_W-1:0] lo_wdata,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] lo_q,
  output logic              done
);
  localparam int ACC_W = 2 * DATA_W;

  logic                    busy;
  logic                    fire;
  mac_ctl_t                ctl_in, ctl_q;
  logic signed [ACC_W-1:0] prod_q;

  assign in_ready = !busy && !clr;
  assign fire     = in_valid && in_ready;
  assign ctl_in   = '{width: mac_width_e'(in_word), sat: in_sat};

  sat_mac_mult #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_mult (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fire),
    .ctl_in   (ctl_in),
    .op_a     (in_a),
    .op_b     (in_b),
    .prod_vld (busy),
    .ctl_q    (ctl_q),
    .prod_q   (prod_q)
  );

  sat_mac_accum #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .prod_vld (busy),
    .ctl      (ctl_q),
    .prod     (prod_q),
    .hi_wr    (hi_wr),
    .hi_wdata (hi_wdata),
    .lo_wr    (lo_wr),
    .lo_wdata (lo_wdata),
    .hi_q     (hi_q),
    .lo_q     (lo_q),
    .done     (done)
  );

  p_done_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fire, 2));

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !in_ready);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/test_sat_mac_unit.sv
`timescale 1ns/1ps
module test_sat_mac_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_word = 0, in_sat = 0, clr = 0, hi_wr = 0, lo_wr = 0;
  logic [31:0] in_a = 0, in_b = 0, hi_wdata = 0, lo_wdata = 0;
  logic in_ready, done;
  logic [31:0] hi_q, lo_q;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  logic [31:0] m_hi = 0, m_lo = 0;
  bit m_busy = 0, m_done = 0;
  bit p_word = 0, p_sat = 0;
  logic [31:0] p_a = 0, p_b = 0;

  always #4 clk = ~clk;

  sat_mac_unit i_sat_mac_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_sat(in_sat), .in_a(in_a), .in_b(in_b), .clr(clr),
    .hi_wr(hi_wr), .hi_wdata(hi_wdata), .lo_wr(lo_wr), .lo_wdata(lo_wdata),
    .hi_q(hi_q), .lo_q(lo_q), .done(done)
  );

  function automatic void ref_mac(input bit w, input bit s, input logic [31:0] a,
                                  input logic [31:0] b, inout logic [31:0] h,
                                  inout logic [31:0] l);
    longint acc, p;
    acc = longint'({h, l});
    if (w) p = longint'(shortint'(a[15:0])) * longint'(shortint'(b[15:0]));
    else   p = longint'(int'(a)) * longint'(int'(b));
    acc = acc + p;
    h = acc[63:32];
    l = acc[31:0];
    if (s) begin
      if (!w) begin
        if (acc < 0) h = h | 32'hFFFF_0000;
        else         h = h & 32'h0000_7FFF;
      end else if (acc < -longint'(64'sd2147483648)) begin
        h = 32'd1; l = 32'h8000_0000;
      end else if (acc > longint'(64'sd2147483647)) begin
        h = 32'd1; l = 32'h7FFF_FFFF;
      end
    end
  endfunction

  task automatic step(input string tag, input bit v, input bit w, input bit s,
                      input logic [31:0] a, input logic [31:0] b, input bit c,
                      input bit hw, input logic [31:0] hd, input bit lw,
                      input logic [31:0] ld);
    bit exp_rdy, fire;
    in_valid = v; in_word = w; in_sat = s; in_a = a; in_b = b; clr = c;
    hi_wr = hw; hi_wdata = hd; lo_wr = lw; lo_wdata = ld;
    #1;
    exp_rdy = !m_busy && !c;
    fire = v && exp_rdy;
    total++;
    if (in_ready !== exp_rdy) begin
      bad++;
      $display("FAIL %s in_ready act=%0b exp=%0b", tag, in_ready, exp_rdy);
    end
    @(posedge clk);
    if (c) begin
      m_hi = 0; m_lo = 0; m_done = 0; m_busy = 0;
    end else if (m_busy) begin
      ref_mac(p_word, p_sat, p_a, p_b, m_hi, m_lo);
      m_done = 1; m_busy = 0;
    end else begin
      m_done = 0;
      if (hw) m_hi = hd;
      if (lw) m_lo = ld;
    end
    if (fire) begin
      m_busy = 1; p_word = w; p_sat = s; p_a = a; p_b = b;
    end
    @(negedge clk);
    total++;
    if (hi_q !== m_hi || lo_q !== m_lo || done !== m_done) begin
      bad++;
      $display("FAIL %s hi act=%h exp=%h lo act=%h exp=%h done act=%0b exp=%0b",
               tag, hi_q, m_hi, lo_q, m_lo, done, m_done);
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic load(input string tag, input logic [31:0] h, input logic [31:0] l);
    step(tag, 0, 0, 0, 0, 0, 0, 1, h, 1, l);
  endtask

  task automatic run_op(input string tag, input bit w, input bit s,
                        input logic [31:0] a, input logic [31:0] b);
    step(tag, 1, w, s, a, b, 0, 0, 0, 0, 0);
    idle(tag);
    idle(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    total++;
    if (hi_q !== 0 || lo_q !== 0 || done !== 0 || in_ready !== 1) begin
      bad++;
      $display("FAIL R1 hi=%h lo=%h done=%0b rdy=%0b exp 0/0/0/1", hi_q, lo_q, done, in_ready);
    end
    // R10 idle writes
    load("R10", 32'h0, 32'h5);
    // R2 long, no clamp
    run_op("R2", 0, 0, -32'sd3, 32'sd7);
    run_op("R2", 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    run_op("R2", 0, 0, 32'h8000_0000, 32'h8000_0000);
    // R4 long clamp both signs
    load("R4", 0, 0);
    run_op("R4", 0, 1, 32'h8000_0000, 32'h7FFF_FFFF);
    load("R4", 0, 0);
    run_op("R4", 0, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    // R3 word form ignores upper bits
    load("R3", 0, 0);
    run_op("R3", 1, 0, 32'hABCD_0003, 32'h1234_FFFE);
    run_op("R3", 1, 0, 32'h5555_8000, 32'hAAAA_8000);
    // R6 word clamp high and in range
    load("R6", 0, 32'h7FFF_FFF0);
    run_op("R6", 1, 1, 32'h0000_0100, 32'h0000_0100);
    load("R6", 0, 0);
    run_op("R6", 1, 1, 32'd5, 32'd5);
    // R5 word clamp low
    load("R5", 32'hFFFF_FFFF, 32'h8000_0005);
    run_op("R5", 1, 1, -32'sd100, 32'd1);
    // R7 request held during busy not taken
    load("R7", 0, 0);
    step("R7", 1, 0, 0, 32'd2, 32'd3, 0, 0, 0, 0, 0);
    step("R7", 1, 0, 0, 32'd2, 32'd3, 0, 0, 0, 0, 0);
    idle("R7");
    idle("R7");
    // R8 clear beats start
    load("R8", 32'h1234, 32'h5678);
    step("R8", 1, 0, 0, 32'd9, 32'd9, 1, 0, 0, 0, 0);
    idle("R8");
    idle("R8");
    // R9 clear cancels in-flight op
    load("R9", 32'h11, 32'h22);
    step("R9", 1, 0, 0, 32'd4, 32'd4, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    idle("R9");
    // R10 writes during flight ignored
    load("R10", 0, 32'd10);
    step("R10", 1, 0, 0, 32'd2, 32'd2, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 1, 32'hDEAD, 1, 32'hBEEF);
    idle("R10");
    // R11 write with start
    step("R11", 1, 1, 0, 32'd3, 32'd3, 0, 1, 32'h0, 1, 32'd100);
    idle("R11");
    idle("R11");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      int sel;
      ra = $urandom;
      rb = $urandom;
      sel = $urandom_range(0, 15);
      if (sel < 3) begin
        ra = {ra[31], 31'h7FFF_FFF0 | ra[3:0]};
        rb = {rb[31], 31'h7FFF_FFF0 | rb[3:0]};
      end
      step("RND", $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, ra, rb, $urandom_range(0, 19) == 0,
           $urandom_range(0, 5) == 0, $urandom, $urandom_range(0, 5) == 0, $urandom);
    end
    idle("end");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule